// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire station-management bus used to configure Ethernet PHYs. Software programs a speed register once, then starts each transaction with a single 32-bit command write. The block sends 32 preamble ones followed by the command word, most significant bit first, on an MDIO data line clocked by a divided MDC. For read frames it releases the line during turnaround and data, samples the PHY's bits, and places them in the low half of the command register.

When a frame ends, a sticky completion flag is set. Software clears it by writing a one to it. A busy flag is high for the whole frame. Command writes that arrive while a frame is in flight, or while the divider is zero, are dropped.

Top module: `mdio_master`

## Requirements
- R1: Register index 0 holds the command word. Bits [31:30] are the start code, [29:28] the opcode (2'b10 means read, any other value means write), [27:23] the PHY address, [22:18] the register address, [17:16] the turnaround and [15:0] the data. An accepted write starts a frame that sends these 32 bits unchanged, MSB first, after the preamble.
- R2: Every frame begins with 32 bit periods in which MDIO is driven to 1. This preamble is never skipped.
- R3: With divider value N (speed register bits [6:1]), MDC has a period of 2N system clocks and is high for N of them. MDC is low whenever no frame is active.
- R4: With hold value H (speed register bits [10:8]), MDIO changes H+1 system clocks after each MDC falling edge. The start of a frame counts as such an edge. Software keeps H at most N-2.
- R5: In a read frame, the output enable is low for the last 18 bit periods: both turnaround bits and 16 data bits. The 16 bits sampled on MDC rising edges replace command register bits [15:0] when the frame ends. Bits [31:16] are not changed.
- R6: Register index 1, bit 0 is a completion flag. It is set at the end of each frame and stays set until a write to index 1 has bit 0 high. A write with bit 0 low leaves it set.
- R7: Register index 1, bit 1 reads 1 while a frame is active. A command write during an active frame changes neither the command register nor the frame on the wire.
- R8: While the divider value is 0, a command write starts no frame and does not change the command register.
- R9: After reset all registers read 0. Register index 2 reads back only its divider and hold fields, and all other bits read 0.
- R10: In a write frame, MDIO is driven for all 64 bit periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_addr_i | input | 2 | Register index (0 command, 1 event/status, 2 speed) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the indexed register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (0 releases the line) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench runs a PHY responder that drives a zero in the second turnaround bit and then a known data word. It checks that the read value lands in the low half of the command register while the upper half stays intact. A design that sampled on the wrong MDC edge or shifted one bit late would return a shifted word.

The bench measures the delay from a frame start and from an MDC fall to the next MDIO change, with hold 3 and divider 5. An off-by-one in the hold counter shows up as 3 or 5 clocks instead of 4. It also writes a command in the middle of a frame. A design without the busy guard would either restart the frame or corrupt the command register.

The bench also writes a command with the divider at 0, where a missing guard would start a frame with a stuck MDC. It clears the completion flag with a zero write and then a one write, where a plain (non-sticky) flag would fail.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int unsigned CMD_W    = 32;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned PRE_LEN  = 32;
    localparam int unsigned DIV_W    = 6;
    localparam int unsigned HOLD_W   = 3;
    localparam int unsigned DIV_LSB  = 1;
    localparam int unsigned HOLD_LSB = 8;
    localparam logic [1:0]  OP_READ  = 2'b10;

    typedef enum logic [1:0] {
        REG_CMD = 2'd0,
        REG_EVT = 2'd1,
        REG_SPD = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == div_i - 1'b1);
        if (!run_i) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        rise_o = run_i && wrap && !st_q.mdc;
        fall_o = run_i && wrap &&  st_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o = st_q.mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
    parameter int unsigned CMD_W   = 32,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PRE_LEN = 32,
    parameter int unsigned HOLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              is_rd_o,
    output logic [DATA_W-1:0] rdat_o,
    output logic              mdo_o,
    output logic              oe_o
);
    import mdio_pkg::OP_READ;

    localparam int unsigned FRAME_LEN = PRE_LEN + CMD_W;
    localparam int unsigned BIT_W     = $clog2(FRAME_LEN);
    localparam logic [BIT_W-1:0] PRE_IDX  = BIT_W'(PRE_LEN);
    localparam logic [BIT_W-1:0] REL_IDX  = BIT_W'(FRAME_LEN - DATA_W - 2);
    localparam logic [BIT_W-1:0] DAT_IDX  = BIT_W'(FRAME_LEN - DATA_W);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic              busy;
        logic              is_rd;
        logic              pend;
        logic [HOLD_W-1:0] hcfg;
        logic [HOLD_W-1:0] hold;
        logic [BIT_W-1:0]  bitn;
        logic [CMD_W-1:0]  sh;
        logic [DATA_W-1:0] rdat;
        logic              mdo;
        logic              oe;
        logic              done;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.is_rd = (cmd_i[CMD_W-3 -: 2] == OP_READ);
                st_d.sh    = cmd_i;
                st_d.bitn  = '0;
                st_d.pend  = 1'b1;
                st_d.hcfg  = hold_i;
                st_d.hold  = hold_i;
                st_d.rdat  = '0;
            end
        end else begin
            if (st_q.pend) begin
                if (st_q.hold == '0) begin
                    st_d.pend = 1'b0;
                    if (st_q.bitn < PRE_IDX) begin
                        st_d.mdo = 1'b1;
                        st_d.oe  = 1'b1;
                    end else begin
                        st_d.mdo = st_q.sh[CMD_W-1];
                        st_d.sh  = st_q.sh << 1;
                        st_d.oe  = !(st_q.is_rd && st_q.bitn >= REL_IDX);
                    end
                end else begin
                    st_d.hold = st_q.hold - 1'b1;
                end
            end
            if (rise_i && st_q.is_rd && st_q.bitn >= DAT_IDX)
                st_d.rdat = {st_q.rdat[DATA_W-2:0], mdio_i};
            if (fall_i) begin
                if (st_q.bitn == LAST_IDX) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.pend = 1'b0;
                    st_d.mdo  = 1'b0;
                    st_d.oe   = 1'b0;
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                    st_d.pend = 1'b1;
                    st_d.hold = st_q.hcfg;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign is_rd_o = st_q.is_rd;
    assign rdat_o  = st_q.rdat;
    assign mdo_o   = st_q.mdo;
    assign oe_o    = st_q.oe;

    // R2: every preamble bit is a driven one when MDC rises
    a_r2_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rise_i && st_q.bitn < PRE_IDX) |-> (st_q.mdo && st_q.oe));
    // R5: line released for turnaround and data of a read
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rise_i && st_q.is_rd && st_q.bitn >= REL_IDX) |-> !st_q.oe);
    // R10: write frames drive every bit
    a_r10_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rise_i && !st_q.is_rd) |-> st_q.oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned DIVW  = DIV_W,
    parameter int unsigned HOLDW = HOLD_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             done;
        logic [DIVW-1:0]  div;
        logic [HOLDW-1:0] hold;
        logic [DIVW-1:0]  run_div;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    start, cmd_wr, evt_clr;
    logic    eng_busy, eng_done, eng_is_rd, mdc_rise, mdc_fall;
    logic [DATA_W-1:0] eng_rdat;

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        cmd_wr  = reg_wr_i && (reg_addr_i == REG_CMD);
        evt_clr = reg_wr_i && (reg_addr_i == REG_EVT) && reg_wdata_i[0];
        if (evt_clr) st_d.done = 1'b0;
        if (eng_done) begin
            st_d.done = 1'b1;
            if (eng_is_rd) st_d.cmd[DATA_W-1:0] = eng_rdat;
        end
        if (cmd_wr && !eng_busy && st_q.div != '0) begin
            st_d.cmd     = reg_wdata_i;
            st_d.run_div = st_q.div;
            start        = 1'b1;
        end
        if (reg_wr_i && reg_addr_i == REG_SPD) begin
            st_d.div  = reg_wdata_i[DIV_LSB +: DIVW];
            st_d.hold = reg_wdata_i[HOLD_LSB +: HOLDW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            REG_CMD: reg_rdata_o = st_q.cmd;
            REG_EVT: reg_rdata_o = {{(CMD_W-2){1'b0}}, eng_busy, st_q.done};
            REG_SPD: begin
                reg_rdata_o[DIV_LSB +: DIVW]   = st_q.div;
                reg_rdata_o[HOLD_LSB +: HOLDW] = st_q.hold;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    mdio_mdc_gen #(.DIV_W(DIVW)) mdc_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy),
        .div_i  (st_q.run_div),
        .mdc_o  (mdc_o),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall)
    );

    mdio_frame_eng #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W),
        .PRE_LEN(PRE_LEN),
        .HOLD_W (HOLDW)
    ) frame_eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .cmd_i   (reg_wdata_i),
        .hold_i  (st_q.hold),
        .rise_i  (mdc_rise),
        .fall_i  (mdc_fall),
        .mdio_i  (mdio_i),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .is_rd_o (eng_is_rd),
        .rdat_o  (eng_rdat),
        .mdo_o   (mdio_o),
        .oe_o    (mdio_oe_o)
    );

    // R3: MDC rests low outside a frame
    a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc_o);
    // R6: completion flag holds until a one is written to it
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !evt_clr) |=> st_q.done);
    // R7: command writes during a frame leave the command fields alone
    a_r7_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && cmd_wr) |=> $stable(st_q.cmd[CMD_W-1:DATA_W]));
    // R8: zero divider never launches a frame
    a_r8_div_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && st_q.div == '0) |=> !eng_busy);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] dat);
        return {2'b01, op, phy, rg, 2'b10, dat};
    endfunction

    function automatic logic phy_bit(input int k, input logic rd, input logic [15:0] v);
        int i;
        i = k - 32;
        if (!rd || i < 0) return 1'b1;
        if (i == 15) return 1'b0;
        if (i >= 16 && i <= 31) return v[31-i];
        return 1'b1;
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int g;
        g = 0;
        do begin rd_reg(2'd1, v); g++; end while (v[1] && g < 5000);
    endtask

    task automatic wait_edge(input logic lvl, output int t);
        logic p;
        int g;
        p = mdc; g = 0;
        forever begin
            @(negedge clk); g++;
            if ((mdc === lvl && p !== lvl) || g > 2000) break;
            p = mdc;
        end
        t = cyc;
    endtask

    // Runs one frame against the PHY model, optionally intruding a command write.
    task automatic capture(input logic rd, input logic [15:0] phy_v, input logic intrude,
                           input logic [31:0] intr_word, output logic [63:0] bits,
                           output logic [63:0] oes, output logic busy_seen);
        logic p;
        int k, g;
        p = mdc; k = 0; g = 0; mdio_i = 1'b1; busy_seen = 1'b0;
        bits = '0; oes = '0;
        while (k < 64 && g < 5000) begin
            @(negedge clk); g++;
            reg_wr = 1'b0;
            if (mdc && !p) begin
                bits[63-k] = mdio_o;
                oes[63-k]  = mdio_oe;
                k++;
                mdio_i = phy_bit(k, rd, phy_v);
                if (intrude && k == 10) begin
                    reg_addr = 2'd0; reg_wdata = intr_word; reg_wr = 1'b1;
                end
                if (k == 20) begin
                    reg_addr = 2'd1;
                    #1 busy_seen = reg_rdata[1];
                end
            end
            p = mdc;
        end
        reg_wr = 1'b0;
        mdio_i = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(2'd0, v); chk("R9 reset cmd", 64'(v), 64'h0);
        rd_reg(2'd1, v); chk("R9 reset evt", 64'(v), 64'h0);
        rd_reg(2'd2, v); chk("R9 reset spd", 64'(v), 64'h0);
        chk("R3 reset mdc/oe", {62'b0, mdc, mdio_oe}, 64'h0);
    endtask

    task automatic t_div_zero();
        logic [31:0] v;
        int toggles;
        toggles = 0;
        wr_reg(2'd0, mk_cmd(2'b01, 5'd1, 5'd1, 16'h1234));
        repeat (30) begin @(negedge clk); if (mdc) toggles++; end
        chk("R8 no mdc with zero divider", 64'(toggles), 64'h0);
        rd_reg(2'd1, v); chk("R8 no busy/done", 64'(v), 64'h0);
        rd_reg(2'd0, v); chk("R8 cmd unchanged", 64'(v), 64'h0);
    endtask

    task automatic t_speed_readback();
        logic [31:0] v;
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd2, v); chk("R9 speed field mask", 64'(v), 64'h77E);
    endtask

    task automatic t_write_frame();
        logic [31:0] cmd, v;
        logic [63:0] bits, oes;
        logic bs;
        cmd = mk_cmd(2'b01, 5'h03, 5'h04, 16'hA5C3);
        wr_reg(2'd2, 32'h4);
        wr_reg(2'd0, cmd);
        capture(1'b0, 16'h0, 1'b0, 32'h0, bits, oes, bs);
        chk("R2 R1 write frame bits", bits, {32'hFFFF_FFFF, cmd});
        chk("R10 write frame driven", oes, {64{1'b1}});
        chk("R7 busy during frame", 64'(bs), 64'h1);
        wait_idle();
        rd_reg(2'd1, v); chk("R6 done after write", 64'(v), 64'h1);
        rd_reg(2'd0, v); chk("R1 cmd kept after write", 64'(v), 64'(cmd));
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr_reg(2'd1, 32'hFFFF_FFFE);
        rd_reg(2'd1, v); chk("R6 zero write keeps done", 64'(v), 64'h1);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v); chk("R6 one write clears done", 64'(v), 64'h0);
    endtask

    task automatic t_read_frame();
        logic [31:0] cmd, v;
        logic [63:0] bits, oes, exp_oe, exp_bits;
        logic bs;
        cmd = mk_cmd(2'b10, 5'h1F, 5'h02, 16'h0000);
        wr_reg(2'd2, 32'h106);
        wr_reg(2'd0, cmd);
        capture(1'b1, 16'h3C96, 1'b0, 32'h0, bits, oes, bs);
        exp_oe   = {{46{1'b1}}, {18{1'b0}}};
        exp_bits = {32'hFFFF_FFFF, cmd};
        chk("R5 read output enable", oes, exp_oe);
        chk("R2 R1 read header bits", bits & exp_oe, exp_bits & exp_oe);
        wait_idle();
        rd_reg(2'd0, v); chk("R5 read data in low half", 64'(v), 64'({cmd[31:16], 16'h3C96}));
        rd_reg(2'd1, v); chk("R6 done after read", 64'(v), 64'h1);
        wr_reg(2'd1, 32'h1);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] cmd, v;
        logic [63:0] bits, oes;
        logic bs;
        cmd = mk_cmd(2'b01, 5'h0A, 5'h11, 16'h0F0F);
        wr_reg(2'd2, 32'h4);
        wr_reg(2'd0, cmd);
        capture(1'b0, 16'h0, 1'b1, mk_cmd(2'b10, 5'h15, 5'h0A, 16'hFFFF), bits, oes, bs);
        chk("R7 frame unaffected by busy write", bits, {32'hFFFF_FFFF, cmd});
        wait_idle();
        rd_reg(2'd0, v); chk("R7 cmd unaffected by busy write", 64'(v), 64'(cmd));
        wr_reg(2'd1, 32'h1);
    endtask

    task automatic t_timing();
        logic [31:0] cmd;
        int c, t1, t2, tf;
        cmd = mk_cmd(2'b01, 5'h01, 5'h01, 16'h8001);
        wr_reg(2'd2, 32'h30A);
        wr_reg(2'd0, cmd);
        c = 0;
        while (mdio_o !== 1'b1 && c < 50) begin @(negedge clk); c++; end
        chk("R4 hold after frame start", 64'(c), 64'd4);
        wait_edge(1'b1, t1);
        wait_edge(1'b0, tf);
        wait_edge(1'b1, t2);
        chk("R3 mdc period", 64'(t2 - t1), 64'd10);
        chk("R3 mdc high time", 64'(tf - t1), 64'd5);
        repeat (30) wait_edge(1'b1, t2);
        wait_edge(1'b0, tf);
        c = 0;
        while (mdio_o !== 1'b0 && c < 50) begin @(negedge clk); c++; end
        chk("R4 hold after mdc fall", 64'(c), 64'd4);
        wait_idle();
        wr_reg(2'd1, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div_zero();
        t_speed_readback();
        t_write_frame();
        t_w1c();
        t_read_frame();
        t_busy_ignore();
        t_timing();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule